// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that lets a bus host read and write a small bank of 8-bit and 16-bit registers through an internal pointer. The open-drain SCL and SDA lines enter through two-flop synchronisers clocked by a faster system clock. Every bus event, whether a clock edge, a START or a STOP, is found by comparing the synchronised lines with their values one system clock earlier. The only output is an active-high enable for a pull-down on SDA. The block never drives SDA high.

A write transaction carries the 7-bit device address with the direction bit LOW. The first data byte after it loads the pointer. Any further bytes go into the selected register. A read transaction returns the selected register, most significant byte first. A host that wants the value of a different register first writes only the pointer, then issues a repeated START and reads. The host acknowledges each byte it wants continued and ends the read with a not-acknowledge.

The controller has eight named states:
- ST_IDLE waits for a START.
- ST_ADDR shifts in the address byte.
- ST_ADDR_ACK pulls SDA low for the address acknowledge.
- ST_WR_BYTE shifts in a written byte.
- ST_WR_ACK acknowledges that byte.
- ST_RD_BYTE drives a byte out.
- ST_RD_ACK samples the host's acknowledge.
- ST_IGNORE stays silent until the next START or STOP.

The transitions are:
- START from any state goes to ST_ADDR.
- STOP from any state goes to ST_IDLE.
- In ST_ADDR, the SCL fall that ends the eighth bit goes to ST_ADDR_ACK on an address match and to ST_IGNORE otherwise.
- ST_ADDR_ACK leaves on the next SCL fall. It goes to ST_RD_BYTE when the direction bit is HIGH and to ST_WR_BYTE when it is LOW.
- ST_WR_BYTE and ST_WR_ACK alternate, each moving on when its byte or its acknowledge clock completes.
- ST_RD_BYTE moves to ST_RD_ACK after eight bits.
- ST_RD_ACK goes back to ST_RD_BYTE on an SCL fall after the host has acknowledged LOW. It goes to ST_IGNORE on an SCL rise that samples a not-acknowledge.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0) and the pointer selects register 0. Register k resets to a high byte of 8'hC0+k. A 16-bit register resets to a low byte of 8'h3C. With the defaults, register 0 is 8-bit and registers 1 to 3 are 16-bit.
- R2: The block ignores all SCL and SDA activity until it sees a START: SDA falling while SCL is high. A STOP (SDA rising while SCL is high) returns it to idle. A START or a repeated START from any state begins a new address byte.
- R3: The address is the first 7 bits of the byte, MSB first, and must equal DEV_ADDR (default 7'h48). The eighth bit is the direction, with 0 meaning write and 1 meaning read. On a mismatch the block gives no acknowledge and drives nothing until the next START or STOP. Registers and the pointer stay unchanged.
- R4: On an address match, and for every byte written after it, the block pulls SDA low for the ninth clock. It releases SDA after that clock's falling edge.
- R5: The first data byte of a write loads the pointer with that byte modulo N_REGS. The register contents stay unchanged.
- R6: Each later byte written to an 8-bit register replaces its value. A 16-bit register takes its high byte first and then its low byte, and both are stored together when the low byte arrives. A high byte with no low byte after it leaves the register unchanged.
- R7: A read returns the register selected by the pointer, high byte first, with the bits MSB first. The pointer keeps its value across transactions, so a repeated START after a pointer-only write reads the new pointer.
- R8: Each host acknowledge (LOW on the ninth clock) brings the next byte. For a 16-bit register that is the low byte, then the high byte again, alternating. An 8-bit register repeats its single byte.
- R9: A not-acknowledge (HIGH on the ninth clock of a read) ends the data phase. SDA stays released for any further clocks until a START or a STOP.
- R10: The block changes sda_oe only while SCL is low, and it is only a pull-down enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
- Directed transactions after reset read every register through a pointer write and a repeated START. This separates the reset values, the pointer modulo rule, the 8-bit and 16-bit read orderings, and a pointer that persists across transactions.
- A byte clocked without any START, and transactions to a neighbouring address, both look for a missing acknowledge and an all-ones read. This separates correct silence from a target that responds too eagerly.
- A lone high byte to a 16-bit register, several bytes to the 8-bit one, and extra clocks after a not-acknowledge each probe a corner where an engine that is off by one byte or one clock would disagree.
- Seeded random register, data and address choices then write and read back values compared with a bench model. A monitor counts every sda_oe change made while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync_bit.sv
module i2c_tgt_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Lines idle high, so the chain resets to 1 to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_line_events.sv
module i2c_tgt_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edges only count as START or STOP with SCL high on both samples.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
    parameter int              N_REGS    = 4,
    parameter logic [N_REGS-1:0] WIDE_MASK = 4'b1110,
    localparam int             PTR_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [15:0]      wr_word,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [15:0]      rd_word,
    output logic             rd_wide
);
    logic [15:0] word_w [N_REGS];

    for (genvar k = 0; k < N_REGS; k++) begin : g_reg
        localparam logic [7:0] RST_HI = 8'hC0 + 8'(k);
        localparam logic [7:0] RST_LO = 8'h3C;
        logic hit;
        assign hit = wr_en && (wr_idx == PTR_W'(k));

        if (WIDE_MASK[k]) begin : g_wide
            logic [15:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= {RST_HI, RST_LO};
                end else if (hit) begin
                    val_q <= wr_word;
                end
            end
            assign word_w[k] = val_q;
        end else begin : g_narrow
            logic [7:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= RST_HI;
                end else if (hit) begin
                    val_q <= wr_word[15:8];
                end
            end
            assign word_w[k] = {val_q, 8'h00};
        end
    end

    assign rd_word = word_w[rd_idx];
    assign rd_wide = WIDE_MASK[rd_idx];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h48,
    parameter int                N_REGS      = 4,
    parameter logic [N_REGS-1:0] WIDE_MASK   = 4'b1110,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PTR_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    tgt_state_e  state, state_nx;
    logic [3:0]  bit_cnt;
    logic [7:0]  rx_sr;
    logic [7:0]  tx_sr;
    logic        rw_q;
    logic        got_ptr;
    logic        wr_lsb;
    logic        rd_lsb;
    logic [7:0]  hold_hi;
    logic [PTR_W-1:0] ptr;

    logic        wr_en;
    logic [15:0] wr_word;
    logic [15:0] rd_word;
    logic        rd_wide;
    logic        byte_done;
    logic        addr_hit;

    i2c_tgt_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );
    i2c_tgt_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2c_tgt_line_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_regfile #(.N_REGS(N_REGS), .WIDE_MASK(WIDE_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(ptr), .wr_word(wr_word),
        .rd_idx(ptr), .rd_word(rd_word), .rd_wide(rd_wide)
    );

    assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
    assign addr_hit  = (rx_sr[7:1] == DEV_ADDR);

    // Next-state logic: bus conditions take priority over every state.
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR:
                    if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) state_nx = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:
                    if (byte_done) state_nx = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:
                    if (byte_done) state_nx = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_rise && sda_s) state_nx = ST_IGNORE;
                    else if (scl_fall)     state_nx = ST_RD_BYTE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Register write: 8-bit registers on every data byte, 16-bit ones on the low byte.
    assign wr_en   = (state == ST_WR_BYTE) && byte_done && got_ptr && !start_det &&
                     !stop_det && (!rd_wide || wr_lsb);
    assign wr_word = rd_wide ? {hold_hi, rx_sr} : {rx_sr, 8'h00};

    // Shift registers, counters and the pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '1;
            rw_q    <= 1'b0;
            got_ptr <= 1'b0;
            wr_lsb  <= 1'b0;
            rd_lsb  <= 1'b0;
            hold_hi <= '0;
            ptr     <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise && bit_cnt < LAST_BIT) begin
                        rx_sr   <= {rx_sr[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done && addr_hit) begin
                        rw_q    <= rx_sr[0];
                        got_ptr <= 1'b0;
                        wr_lsb  <= 1'b0;
                        rd_lsb  <= 1'b0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) tx_sr <= rd_word[15:8];
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise && bit_cnt < LAST_BIT) begin
                        rx_sr   <= {rx_sr[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        if (!got_ptr) begin
                            ptr     <= PTR_W'(32'(rx_sr) % N_REGS);
                            got_ptr <= 1'b1;
                            wr_lsb  <= 1'b0;
                        end else if (rd_wide && !wr_lsb) begin
                            hold_hi <= rx_sr;
                            wr_lsb  <= 1'b1;
                        end else begin
                            wr_lsb  <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_RD_BYTE: begin
                    if (scl_rise && bit_cnt < LAST_BIT) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (scl_fall && bit_cnt != '0 && bit_cnt < LAST_BIT) begin
                        tx_sr <= {tx_sr[6:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_wide && !rd_lsb) begin
                            tx_sr  <= rd_word[7:0];
                            rd_lsb <= 1'b1;
                        end else begin
                            tx_sr  <= rd_word[15:8];
                            rd_lsb <= 1'b0;
                        end
                    end
                end
                default: begin
                    bit_cnt <= bit_cnt;
                end
            endcase
        end
    end

    // Output: pull-down enable only, decoded from registered state.
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sr[7];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input logic       clk,
    input logic       rst_n,
    input tgt_state_e state,
    input logic [3:0] bit_cnt,
    input logic [7:0] rx_sr,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe
);
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    assert_quiet_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE || state == ST_ADDR) |-> !sda_oe);

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == 4'd0));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));

    assert_mismatch_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bit_cnt == 4'd8 && rx_sr[7:1] != DEV_ADDR &&
         !start_det && !stop_det) |=> (state == ST_IGNORE));

    assert_ack_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sda_oe);

    assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .bit_cnt(bit_cnt), .rx_sr(rx_sr),
    .scl_s(scl_s), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'h48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int r10_viol = 0;

    logic [15:0] m_reg [4];
    int m_ptr = 0;
    logic [7:0] wbuf [8];

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_reg_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    // R10 monitor: sda_oe must hold while SCL stays high.
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) r10_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    function automatic bit is_wide(int k);
        return k != 0;
    endfunction

    function automatic logic [7:0] exp_byte(int k, int i);
        if (is_wide(k) && (i % 2 == 1)) return m_reg[k][7:0];
        return m_reg[k][15:8];
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_m = b;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        r = sda_line;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b1;
        wait_q();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
        clock_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            d[i] = r;
        end
        clock_bit(!give_ack, r);
    endtask

    // Write transaction: address, then n bytes from wbuf; the model follows R5/R6.
    task automatic wr_txn(input logic [6:0] a, input int n, input bit do_stop);
        logic ack;
        bit hit = (a == DEV);
        int widx = 0;
        logic [7:0] hold = 8'h00;
        bus_start();
        write_byte({a, 1'b0}, ack);
        check(ack == hit, hit ? "R4 address ack" : "R3 mismatch no ack", 16'(ack), 16'(hit));
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], ack);
            check(ack == hit, "R4 data byte ack", 16'(ack), 16'(hit));
            if (hit) begin
                if (i == 0) begin
                    m_ptr = int'(wbuf[0]) % 4;
                    widx = 0;
                end else if (is_wide(m_ptr)) begin
                    if (widx == 0) begin
                        hold = wbuf[i];
                        widx = 1;
                    end else begin
                        m_reg[m_ptr] = {hold, wbuf[i]};
                        widx = 0;
                    end
                end else begin
                    m_reg[m_ptr][15:8] = wbuf[i];
                end
            end
        end
        if (do_stop) bus_stop();
    endtask

    // Read transaction: n bytes, ack all but the last (R7/R8).
    task automatic rd_txn(input logic [6:0] a, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bit hit = (a == DEV);
        bus_start();
        write_byte({a, 1'b1}, ack);
        check(ack == hit, hit ? "R4 read address ack" : "R3 read mismatch", 16'(ack), 16'(hit));
        for (int i = 0; i < n; i++) begin
            read_byte(i < n - 1, d);
            if (hit) check(d == exp_byte(m_ptr, i), req, 16'(d), 16'(exp_byte(m_ptr, i)));
            else     check(d == 8'hFF, "R3 silent on mismatch", 16'(d), 16'hFF);
        end
        bus_stop();
    endtask

    task automatic ptr_read(input int p, input int n, input string req);
        wbuf[0] = 8'(p);
        wr_txn(DEV, 1, 1'b0);
        rd_txn(DEV, n, req);
    endtask

    task automatic finish_run();
        tests++;
        if (r10_viol != 0) begin
            fails++;
            $display("FAIL R10: actual %0d oe changes with SCL high expected 0", r10_viol);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        for (int k = 0; k < 4; k++) m_reg[k] = {8'hC0 + 8'(k), is_wide(k) ? 8'h3C : 8'h00};

        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset releases SDA", 16'(sda_oe), 16'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 released after reset", 16'(sda_oe), 16'h0);

        // R2: a matching address byte without START gets no acknowledge.
        write_byte({DEV, 1'b0}, ack);
        check(ack == 1'b0, "R2 no response before START", 16'(ack), 16'h0);
        bus_stop();

        // R1: pointer starts at 0, read without a pointer write.
        rd_txn(DEV, 1, "R1 reset pointer reads reg0");
        // R1/R7: reset values through pointer write + repeated START.
        for (int k = 0; k < 4; k++) ptr_read(k, is_wide(k) ? 2 : 1, "R7 R1 reset value read");

        // R3: mismatched address writes nothing and reads nothing.
        wbuf[0] = 8'h01; wbuf[1] = 8'hDE; wbuf[2] = 8'hAD;
        wr_txn(DEV ^ 7'h01, 3, 1'b1);
        rd_txn(DEV ^ 7'h10, 2, "R3");
        ptr_read(1, 2, "R3 register unchanged after mismatch");

        // R5: pointer byte taken modulo 4 (0x06 selects register 2).
        ptr_read(6, 2, "R5 pointer modulo");

        // R6: lone high byte leaves a 16-bit register unchanged.
        wbuf[0] = 8'h01; wbuf[1] = 8'h77;
        wr_txn(DEV, 2, 1'b1);
        check(m_reg[1] == 16'hC13C, "R6 model sanity lone high byte", m_reg[1], 16'hC13C);
        ptr_read(1, 2, "R6 lone high byte ignored");

        // R6: 8-bit register, last of several bytes wins.
        wbuf[0] = 8'h00; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
        wr_txn(DEV, 3, 1'b1);
        ptr_read(0, 1, "R6 narrow last byte wins");

        // R6/R8: full 16-bit write then a 4-byte read alternates high/low.
        wbuf[0] = 8'h03; wbuf[1] = 8'hA5; wbuf[2] = 8'h5A;
        wr_txn(DEV, 3, 1'b1);
        ptr_read(3, 4, "R8 wide alternation");
        ptr_read(0, 3, "R8 narrow repeats");

        // R7: pointer persists across separate transactions.
        wbuf[0] = 8'h02;
        wr_txn(DEV, 1, 1'b1);
        rd_txn(DEV, 2, "R7 pointer persists");

        // R9: after a not-acknowledge the target stays silent.
        bus_start();
        write_byte({DEV, 1'b1}, ack);
        read_byte(1'b0, d);
        check(d == exp_byte(m_ptr, 0), "R9 first byte before NACK", 16'(d), 16'(exp_byte(m_ptr, 0)));
        read_byte(1'b0, d);
        check(d == 8'hFF, "R9 released after NACK", 16'(d), 16'hFF);
        bus_stop();

        // Random write/read-back mixed with mismatched addresses.
        for (int it = 0; it < 28; it++) begin
            int k = int'($urandom % 4);
            bit bad = ($urandom % 6) == 0;
            logic [6:0] a = bad ? (DEV ^ 7'(1 + $urandom % 127)) : DEV;
            wbuf[0] = 8'(k + 4 * int'($urandom % 64));
            wbuf[1] = 8'($urandom);
            wbuf[2] = 8'($urandom);
            wr_txn(a, is_wide(k) ? 3 : 2, 1'b1);
            ptr_read(k, is_wide(k) ? 2 : 1, "R6 R7 random readback");
        end

        done = 1'b1;
        finish_run();
    end
endmodule